// File: doc/BRIEF.md
# Bidirectional Row Scan Shifter with Drive Level Encoding

This block is the row (common) side of a large display driver. It holds one scan register stage per drive output. Each falling edge of the line pulse moves a scan token one stage along the register. The direction input picks the end where data enters. The pin at the opposite end carries the last stage out, so several chips can be chained.

The two end pins are bidirectional. Each is brought out as an input, an output and an output enable. The block drives the enables to match the scan direction.

Every stage is encoded into a 2-bit drive level code, one of four levels: 00 for the highest level, 01 for upper-middle, 10 for lower-middle and 11 for the lowest. The code depends on the register bit, the frame polarity and the active-low display-off input. Analog levels are generated elsewhere.

The line pulse is sampled on the system clock. A falling edge is a cycle where the line pulse is low after being high in the previous cycle.

Top module: `com_scan_drv`

## Requirements
- R1: An active-low asynchronous reset clears every register stage and the line-pulse history. After reset, with frame polarity 1 and display on, every output code is 01.
- R2: With direction 0 in row mode, each line-pulse falling edge loads `end_a_in` into stage 0 and moves stage k to stage k+1.
- R3: With direction 1 in row mode, each line-pulse falling edge loads `end_b_in` into stage N-1 and moves stage k to stage k-1.
- R4: A rising edge of the line pulse, or a line pulse that stays high or stays low, leaves the register unchanged.
- R5: In row mode, direction 0 sets `end_b_oe`=1 and `end_a_oe`=0. Direction 1 sets `end_a_oe`=1 and `end_b_oe`=0. In column mode both enables are 0.
- R6: `end_b_out` always equals stage N-1 and `end_a_out` always equals stage 0. A token entered at one end therefore appears at the far output pin after N falling edges and leaves it on the next falling edge.
- R7: With display on, stage k drives bits [2k+1:2k] of `drive_lvl`. A bit of 1 gives 00 when frame polarity is 1 and 11 when it is 0. A bit of 0 gives 01 when frame polarity is 1 and 10 when it is 0.
- R8: In column mode (`seg_mode`=1) the same bit-to-code mapping applies, and line-pulse edges do not shift the register.
- R9: While `disp_off_n` is 0, every code is 11 whatever the data and frame polarity. The register still shifts on line-pulse falling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lp | input | 1 | Line pulse; register shifts on its falling edge |
| dir | input | 1 | Scan direction: 0 = A toward B, 1 = B toward A |
| seg_mode | input | 1 | 1 = column mode, 0 = row (scan) mode |
| fr | input | 1 | Frame polarity |
| disp_off_n | input | 1 | Active-low display off |
| end_a_in | input | 1 | End A pin, input side |
| end_a_out | output | 1 | End A pin, output side (stage 0) |
| end_a_oe | output | 1 | End A pin output enable |
| end_b_in | input | 1 | End B pin, input side |
| end_b_out | output | 1 | End B pin, output side (stage N-1) |
| end_b_oe | output | 1 | End B pin output enable |
| drive_lvl | output | 2*STAGES | Two-bit level code per stage |

## Verification
A line-pulse falling edge and the display-off override can land in the same cycle. In that case the outputs must all read 11 while the register still advances underneath.

The bench holds `disp_off_n` low across a falling edge with a token in the register. It checks that every code is 11 during that period. After releasing the override, it checks that the token appears one stage further on, with the code that matches the frame polarity.

// File: rtl/com_scan_drv.sv
module com_scan_drv #(
  parameter int STAGES = 240
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lp,
  input  logic                dir,
  input  logic                seg_mode,
  input  logic                fr,
  input  logic                disp_off_n,
  input  logic                end_a_in,
  output logic                end_a_out,
  output logic                end_a_oe,
  input  logic                end_b_in,
  output logic                end_b_out,
  output logic                end_b_oe,
  output logic [2*STAGES-1:0] drive_lvl
);

  logic              lp_q;
  logic              lp_fall;
  logic              shift_en;
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lp_q <= 1'b0;
    else        lp_q <= lp;

  assign lp_fall  = lp_q & ~lp;
  assign shift_en = lp_fall & ~seg_mode;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        sr <= '0;
    else if (shift_en) sr <= dir ? {end_b_in, sr[STAGES-1:1]} : {sr[STAGES-2:0], end_a_in};

  assign end_a_oe  = ~seg_mode & dir;
  assign end_b_oe  = ~seg_mode & ~dir;
  assign end_a_out = sr[0];
  assign end_b_out = sr[STAGES-1];

  for (genvar g = 0; g < STAGES; g++) begin : g_lvl
    assign drive_lvl[2*g +: 2] = disp_off_n ? {~fr, sr[g] ^ fr} : 2'b11;
  end

  // R2
  fwd_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_fall && !seg_mode && !dir) |=> (sr[0] == $past(end_a_in)) && (end_b_out == $past(sr[STAGES-2])));

  // R3
  rev_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_fall && !seg_mode && dir) |=> (sr[STAGES-1] == $past(end_b_in)) && (end_a_out == $past(sr[1])));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lp_q && !lp) |=> $stable(sr));

  // R8
  seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_mode |=> $stable(sr));

  // R9
  dispoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_off_n |-> (&drive_lvl));

  // R5
  oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(end_a_oe && end_b_oe) && (seg_mode || (end_a_oe != end_b_oe)));

endmodule

// File: tb/com_scan_drv_bench.sv
`timescale 1ns/1ps
module com_scan_drv_bench;
  localparam int N = 240;

  logic clk = 0, rst_n = 0, lp = 0, dir = 0, seg_mode = 0, fr = 1, disp_off_n = 1;
  logic end_a_in = 0, end_b_in = 0;
  logic end_a_out, end_a_oe, end_b_out, end_b_oe;
  logic [2*N-1:0] drive_lvl;
  logic [N-1:0] m;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  com_scan_drv #(.STAGES(N)) u_com_scan_drv (
    .clk(clk), .rst_n(rst_n), .lp(lp), .dir(dir), .seg_mode(seg_mode), .fr(fr),
    .disp_off_n(disp_off_n), .end_a_in(end_a_in), .end_a_out(end_a_out), .end_a_oe(end_a_oe),
    .end_b_in(end_b_in), .end_b_out(end_b_out), .end_b_oe(end_b_oe), .drive_lvl(drive_lvl));

  function automatic logic [1:0] exp_code(logic b, logic f, logic don);
    if (!don) return 2'b11;
    case ({b, f})
      2'b11:   return 2'b00;
      2'b10:   return 2'b11;
      2'b01:   return 2'b01;
      default: return 2'b10;
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_levels(string req);
    int bad = -1;
    for (int k = 0; k < N; k++)
      if (bad < 0 && drive_lvl[2*k +: 2] !== exp_code(m[k], fr, disp_off_n)) bad = k;
    if (bad < 0) chk(1, req, 0, 0);
    else chk(0, $sformatf("%s stage %0d", req, bad), drive_lvl[2*bad +: 2], exp_code(m[bad], fr, disp_off_n));
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 0; lp = 0; m = '0;
    @(negedge clk) rst_n = 1;
    @(negedge clk);
  endtask

  task automatic pulse();
    @(negedge clk) lp = 1;
    @(negedge clk) lp = 0;
    if (!seg_mode) m = dir ? {end_b_in, m[N-1:1]} : {m[N-2:0], end_a_in};
    @(negedge clk);
  endtask

  task automatic t_reset();
    fr = 1; disp_off_n = 1; seg_mode = 0; dir = 0;
    do_reset();
    chk_levels("R1 reset codes");
    chk(drive_lvl[1:0] === 2'b01, "R1 stage0 code", drive_lvl[1:0], 2'b01);
  endtask

  task automatic t_forward();
    do_reset(); dir = 0; end_a_in = 1;
    pulse(); end_a_in = 0;
    chk(drive_lvl[1:0] === 2'b00, "R2 token at stage0", drive_lvl[1:0], 2'b00);
    pulse(); pulse();
    chk_levels("R2 token moved to stage2");
    chk(drive_lvl[5:4] === 2'b00, "R2 stage2 code", drive_lvl[5:4], 2'b00);
  endtask

  task automatic t_reverse();
    do_reset(); dir = 1; end_b_in = 1;
    pulse(); end_b_in = 0; pulse();
    chk_levels("R3 reverse token");
    chk(drive_lvl[2*(N-2) +: 2] === 2'b00, "R3 stage N-2", drive_lvl[2*(N-2) +: 2], 2'b00);
  endtask

  task automatic t_hold();
    do_reset(); dir = 0; end_a_in = 1; pulse(); end_a_in = 1;
    @(negedge clk) lp = 1;
    repeat (4) @(negedge clk);
    chk_levels("R4 rising edge and high lp");
    @(negedge clk) lp = 1; end_a_in = 0;
    @(negedge clk) lp = 0;
    m = {m[N-2:0], 1'b0};
    repeat (3) @(negedge clk);
    chk_levels("R4 low lp holds after fall");
  endtask

  task automatic t_oe();
    seg_mode = 0; dir = 0; #1;
    chk({end_a_oe, end_b_oe} === 2'b01, "R5 dir0 enables", {end_a_oe, end_b_oe}, 2'b01);
    dir = 1; #1;
    chk({end_a_oe, end_b_oe} === 2'b10, "R5 dir1 enables", {end_a_oe, end_b_oe}, 2'b10);
    seg_mode = 1; #1;
    chk({end_a_oe, end_b_oe} === 2'b00, "R5 column mode enables", {end_a_oe, end_b_oe}, 2'b00);
    seg_mode = 0; dir = 0;
  endtask

  task automatic t_cascade();
    do_reset(); dir = 0; end_a_in = 1; pulse(); end_a_in = 0;
    for (int i = 1; i < N - 1; i++) pulse();
    chk(end_b_out === 1'b0, "R6 not yet at far pin", end_b_out, 0);
    pulse();
    chk(end_b_out === 1'b1, "R6 token at far pin", end_b_out, 1);
    pulse();
    chk(end_b_out === 1'b0, "R6 token left far pin", end_b_out, 0);
    dir = 1; end_b_in = 1; pulse(); end_b_in = 0;
    chk(end_a_out === 1'b0, "R6 end_a_out stage0", end_a_out, 0);
    dir = 0;
  endtask

  task automatic t_levels();
    do_reset(); dir = 0; end_a_in = 1; pulse(); pulse(); end_a_in = 0; pulse();
    fr = 1; #1; chk_levels("R7 fr=1 mixed");
    fr = 0; #1; chk_levels("R7 fr=0 mixed");
    chk(drive_lvl[3:0] === 4'b1110, "R7 fr=0 stages1,0", drive_lvl[3:0], 4'b1110);
    fr = 1;
  endtask

  task automatic t_segment();
    do_reset(); dir = 0; end_a_in = 1; pulse(); end_a_in = 1;
    seg_mode = 1; pulse(); pulse();
    chk_levels("R8 column mode no shift");
    fr = 0; #1; chk_levels("R8 column mode fr=0");
    fr = 1; seg_mode = 0; end_a_in = 0;
  endtask

  task automatic t_dispoff_shift();
    do_reset(); dir = 0; end_a_in = 1; pulse(); end_a_in = 0;
    disp_off_n = 0;
    @(negedge clk) lp = 1;
    @(negedge clk) lp = 0;
    m = {m[N-2:0], 1'b0};
    chk(&drive_lvl, "R9 forced during shift", drive_lvl[31:0], 32'hffffffff);
    @(negedge clk);
    chk_levels("R9 all codes 11");
    disp_off_n = 1; #1;
    chk_levels("R9 token advanced under override");
    chk(drive_lvl[3:2] === 2'b00, "R9 stage1 after release", drive_lvl[3:2], 2'b00);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m = '0;
    repeat (2) @(negedge clk);
    t_reset();
    t_forward();
    t_reverse();
    t_hold();
    t_oe();
    t_cascade();
    t_levels();
    t_segment();
    t_dispoff_shift();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule